// File: doc/BRIEF.md
# Data Memory Address Generator

This block turns the short file-register field of a data-memory instruction into a full data-memory address. An 8-bit field on its own reaches only 256 locations. The block widens it in one of three ways, chosen by a one-bit select from the instruction:

- **Through a bank register.** The 4-bit bank register supplies the upper address bits.
- **Through a fixed split window.** The low part of the field reaches the bottom of memory, and the high part reaches the special-register area at the top.
- **Through a stack-pointer offset.** When the extended-instruction mode is on, the low part of the window becomes an offset added to a stack-pointer value.

The bank register lives inside the block. A move-literal-to-bank load writes it, and it keeps its value until the next load.

Two-word register-to-register moves carry complete 12-bit addresses in their instruction words. An absolute-select input passes such an address straight through, ignoring the bank register, the field and the select bit. The address output is combinational, so the address for the current instruction is ready in the same cycle. Only the bank register is clocked.

Top module: `dmag_addr_gen`

## Requirements
- R1: After a synchronous active-low reset, the bank register reads 0. With `bank_sel`=1 and `abs_sel`=0, the address is then `{4'h0, fld}`.
- R2: With `abs_sel`=0, `bank_sel`=0, `ext_en`=0 and `fld` below 0x60, `addr` = `{4'h0, fld}`. This covers the boundary value 0x5F.
- R3: With `abs_sel`=0, `bank_sel`=0 and `fld` of 0x60 or more, `addr` = `{4'hF, fld}` (0xF60 to 0xFFF). This holds whatever the value of `ext_en`.
- R4: With `abs_sel`=0 and `bank_sel`=1, `addr` = `{bank, fld}`. Here `bank` is the 4-bit bank register value. Neither `ext_en` nor `stk_ptr` has any effect.
- R5: With `abs_sel`=0, `bank_sel`=0, `ext_en`=1 and `fld` below 0x60, `addr` = `stk_ptr + fld`. The field is taken as an unsigned offset.
- R6: The R5 sum wraps modulo 4096. For example, `stk_ptr`=0xFF0 with `fld`=0x20 gives 0x010.
- R7: With `abs_sel`=1, `addr` = `abs_addr`. The register, field, select bit and mode have no effect.
- R8: When `bank_load`=1 at a rising clock edge, `bank_lit` is written to the bank register, visible on `bank_q` after that edge. When `bank_load`=0, the bank register holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_load | input | 1 | Write `bank_lit` into the bank register |
| bank_lit | input | 4 | Literal for the bank register |
| fld | input | 8 | File field from the instruction |
| bank_sel | input | 1 | 1: banked addressing; 0: split window |
| ext_en | input | 1 | Extended-instruction mode enable |
| stk_ptr | input | 12 | Stack-pointer value used as the offset base |
| abs_sel | input | 1 | Use `abs_addr` unchanged (two-word move) |
| abs_addr | input | 12 | Absolute address from a move instruction word |
| addr | output | 12 | Effective data-memory address |
| bank_q | output | 4 | Current bank register value |

## Verification
The bench builds the block with its default parameters: an 8-bit field, a 4-bit bank register and a window split at 0x60. With these values the 12-bit address space and its wrap point lie within reach of directed patterns.

The split boundary is tested on both sides, at 0x5F and 0x60, in both modes. The stack-pointer sum is pushed past 0xFFF to exercise the wrap. Bank loads are interleaved with idle cycles to show that the register holds its value between loads.

// File: rtl/dmag_pkg.sv
// Package: dmag_pkg
// Shared types for the data memory address generator.
// Assumes: every user compiles this package first.
package dmag_pkg;
    // Which source forms the effective address.
    typedef enum logic [2:0] {
        SRC_LOW   = 3'd0,   // low window, absolute
        SRC_HIGH  = 3'd1,   // high special-register window
        SRC_BANK  = 3'd2,   // bank register concatenated with field
        SRC_STACK = 3'd3,   // stack pointer plus field offset
        SRC_ABS   = 3'd4    // full address from a move instruction word
    } addr_src_e;
endpackage

// File: rtl/dmag_bank_reg.sv
// Module: dmag_bank_reg
// Holds the bank register. It is loaded from a literal and otherwise keeps its value.
// Assumes: the reset is synchronous and active-low; the reset value is 0.
module dmag_bank_reg #(
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BANK_W-1:0] lit,
    output logic [BANK_W-1:0] q
);
    // Bank register: reset, load, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= lit;
        end
    end
endmodule

// File: rtl/dmag_classify.sv
// Module: dmag_classify
// Picks the address source from the absolute select, the bank select,
// the extended-mode enable and the position of the field relative to the split.
// Assumes: SPLIT is the first field value that falls in the high window.
module dmag_classify
    import dmag_pkg::*;
#(
    parameter int               FIELD_W = 8,
    parameter logic [FIELD_W-1:0] SPLIT = 8'h60
) (
    input  logic [FIELD_W-1:0] fld,
    input  logic               bank_sel,
    input  logic               ext_en,
    input  logic               abs_sel,
    output addr_src_e          src
);
    logic in_low;

    // Field position: below the split means the low window.
    always_comb in_low = (fld < SPLIT);

    // Source choice, absolute move first, then bank, then the window split.
    always_comb begin
        if (abs_sel) begin
            src = SRC_ABS;
        end else if (bank_sel) begin
            src = SRC_BANK;
        end else if (!in_low) begin
            src = SRC_HIGH;
        end else if (ext_en) begin
            src = SRC_STACK;
        end else begin
            src = SRC_LOW;
        end
    end
endmodule

// File: rtl/dmag_offset_add.sv
// Module: dmag_offset_add
// Adds an unsigned field offset to a base pointer.
// Assumes: the sum wraps modulo 2**ADDR_W; no carry out is kept.
module dmag_offset_add #(
    parameter int FIELD_W = 8,
    parameter int ADDR_W  = 12
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [FIELD_W-1:0] ofs,
    output logic [ADDR_W-1:0]  sum
);
    logic [ADDR_W-1:0] ofs_ext;

    // Zero-extend the offset to the address width.
    always_comb ofs_ext = {{(ADDR_W-FIELD_W){1'b0}}, ofs};

    // Add with wrap; bits above the address width are dropped.
    always_comb sum = base + ofs_ext;
endmodule

// File: rtl/dmag_addr_gen.sv
// Module: dmag_addr_gen (top)
// Forms the effective data-memory address from the file field, the bank
// select bit, the bank register, the extended-mode stack pointer, or a full
// absolute address from a two-word move.
// Assumes: address width = bank width + field width. The address is
// combinational; only the bank register is clocked.
module dmag_addr_gen
    import dmag_pkg::*;
#(
    parameter int                 FIELD_W = 8,
    parameter int                 BANK_W  = 4,
    parameter logic [FIELD_W-1:0] SPLIT   = 8'h60
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bank_load,
    input  logic [BANK_W-1:0]           bank_lit,
    input  logic [FIELD_W-1:0]          fld,
    input  logic                        bank_sel,
    input  logic                        ext_en,
    input  logic [FIELD_W+BANK_W-1:0]   stk_ptr,
    input  logic                        abs_sel,
    input  logic [FIELD_W+BANK_W-1:0]   abs_addr,
    output logic [FIELD_W+BANK_W-1:0]   addr,
    output logic [BANK_W-1:0]           bank_q
);
    localparam int ADDR_W = FIELD_W + BANK_W;

    addr_src_e          src;
    logic [BANK_W-1:0]  bank;
    logic [ADDR_W-1:0]  stk_sum;

    dmag_bank_reg #(.BANK_W(BANK_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (bank_load),
        .lit   (bank_lit),
        .q     (bank)
    );

    dmag_classify #(.FIELD_W(FIELD_W), .SPLIT(SPLIT)) u_cls (
        .fld      (fld),
        .bank_sel (bank_sel),
        .ext_en   (ext_en),
        .abs_sel  (abs_sel),
        .src      (src)
    );

    dmag_offset_add #(.FIELD_W(FIELD_W), .ADDR_W(ADDR_W)) u_add (
        .base (stk_ptr),
        .ofs  (fld),
        .sum  (stk_sum)
    );

    // Address mux: select the formed address by source.
    always_comb begin
        unique case (src)
            SRC_ABS:   addr = abs_addr;
            SRC_BANK:  addr = {bank, fld};
            SRC_HIGH:  addr = {{BANK_W{1'b1}}, fld};
            SRC_STACK: addr = stk_sum;
            default:   addr = {{BANK_W{1'b0}}, fld};
        endcase
    end

    // Expose the bank register for observation.
    always_comb bank_q = bank;
endmodule

// File: rtl/dmag_addr_chk.sv
// Module: dmag_addr_chk
// Checker for dmag_addr_gen; attached by the bind statement at the end of this file.
// Assumes: default parameter relations (ADDR_W = FIELD_W + BANK_W).
module dmag_addr_chk #(
    parameter int                 FIELD_W = 8,
    parameter int                 BANK_W  = 4,
    parameter logic [FIELD_W-1:0] SPLIT   = 8'h60
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bank_load,
    input logic [BANK_W-1:0]          bank_lit,
    input logic [FIELD_W-1:0]         fld,
    input logic                       bank_sel,
    input logic                       ext_en,
    input logic [FIELD_W+BANK_W-1:0]  stk_ptr,
    input logic                       abs_sel,
    input logic [FIELD_W+BANK_W-1:0]  abs_addr,
    input logic [FIELD_W+BANK_W-1:0]  addr,
    input logic [BANK_W-1:0]          bank_q
);
    p_abs_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        abs_sel |-> addr == abs_addr);

    p_banked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!abs_sel && bank_sel) |-> addr == {bank_q, fld});

    p_high_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!abs_sel && !bank_sel && fld >= SPLIT)
            |-> (addr[FIELD_W-1:0] == fld && &addr[FIELD_W+BANK_W-1:FIELD_W]));

    p_low_abs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!abs_sel && !bank_sel && !ext_en && fld < SPLIT)
            |-> addr == {{BANK_W{1'b0}}, fld});

    p_bank_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bank_load |=> bank_q == $past(bank_lit));

    p_bank_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_load |=> $stable(bank_q));
endmodule

bind dmag_addr_gen dmag_addr_chk #(
    .FIELD_W(FIELD_W), .BANK_W(BANK_W), .SPLIT(SPLIT)
) u_chk (.*);

// File: tb/sim_dmag_addr_gen.sv
// Bench: sim_dmag_addr_gen
// Directed tests, one task for each scenario, each task checking its own results.
module sim_dmag_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bank_load;
    logic [3:0]  bank_lit;
    logic [7:0]  fld;
    logic        bank_sel;
    logic        ext_en;
    logic [11:0] stk_ptr;
    logic        abs_sel;
    logic [11:0] abs_addr;
    logic [11:0] addr;
    logic [3:0]  bank_q;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;   // 125 MHz

    dmag_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .bank_load(bank_load), .bank_lit(bank_lit),
        .fld(fld), .bank_sel(bank_sel), .ext_en(ext_en), .stk_ptr(stk_ptr),
        .abs_sel(abs_sel), .abs_addr(abs_addr), .addr(addr), .bank_q(bank_q)
    );

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%03h expected=%03h", req, act, exp);
        end
    endtask

    // Apply a combinational pattern and check the address after settling.
    task automatic apply(input string req, input logic a, input logic x, input logic [7:0] f,
                         input logic [11:0] sp, input logic [11:0] exp);
        @(negedge clk);
        abs_sel = 1'b0; bank_sel = a; ext_en = x; fld = f; stk_ptr = sp;
        #1;
        chk(req, addr, exp);
    endtask

    task automatic load_bank(input logic [3:0] v);
        @(negedge clk);
        bank_load = 1'b1; bank_lit = v;
        @(negedge clk);
        bank_load = 1'b0; bank_lit = ~v;
    endtask

    task automatic t_reset_r1();
        @(negedge clk);
        bank_lit = 4'hA; bank_load = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        bank_load = 1'b0; rst_n = 1'b1;
        chk("R1 bank_q", {8'h0, bank_q}, 12'h000);
        apply("R1 banked", 1'b1, 1'b0, 8'h34, 12'h000, 12'h034);
    endtask

    task automatic t_low_r2();
        apply("R2 f=00", 1'b0, 1'b0, 8'h00, 12'h7A0, 12'h000);
        apply("R2 f=2B", 1'b0, 1'b0, 8'h2B, 12'h7A0, 12'h02B);
        apply("R2 f=5F", 1'b0, 1'b0, 8'h5F, 12'h7A0, 12'h05F);
    endtask

    task automatic t_high_r3();
        apply("R3 f=60", 1'b0, 1'b0, 8'h60, 12'h100, 12'hF60);
        apply("R3 f=FF", 1'b0, 1'b0, 8'hFF, 12'h100, 12'hFFF);
        apply("R3 ext f=60", 1'b0, 1'b1, 8'h60, 12'h100, 12'hF60);
        apply("R3 ext f=C3", 1'b0, 1'b1, 8'hC3, 12'h100, 12'hFC3);
    endtask

    task automatic t_bank_r4();
        load_bank(4'h5);
        apply("R4 bank5", 1'b1, 1'b0, 8'h12, 12'h300, 12'h512);
        apply("R4 bank5 ext", 1'b1, 1'b1, 8'h12, 12'h300, 12'h512);
        apply("R4 bank5 f=80", 1'b1, 1'b1, 8'h80, 12'hABC, 12'h580);
    endtask

    task automatic t_stack_r5();
        apply("R5 sp+00", 1'b0, 1'b1, 8'h00, 12'h240, 12'h240);
        apply("R5 sp+5F", 1'b0, 1'b1, 8'h5F, 12'h240, 12'h29F);
        apply("R5 sp+11", 1'b0, 1'b1, 8'h11, 12'h0F8, 12'h109);
    endtask

    task automatic t_wrap_r6();
        apply("R6 wrap", 1'b0, 1'b1, 8'h20, 12'hFF0, 12'h010);
        apply("R6 wrap top", 1'b0, 1'b1, 8'h01, 12'hFFF, 12'h000);
    endtask

    task automatic t_abs_r7();
        @(negedge clk);
        abs_sel = 1'b1; abs_addr = 12'h9C4; bank_sel = 1'b1; ext_en = 1'b1; fld = 8'h10;
        #1; chk("R7 abs a=1", addr, 12'h9C4);
        bank_sel = 1'b0; fld = 8'hF0; abs_addr = 12'h003;
        #1; chk("R7 abs a=0", addr, 12'h003);
        abs_sel = 1'b0;
    endtask

    task automatic t_load_r8();
        load_bank(4'hC);
        chk("R8 load", {8'h0, bank_q}, 12'h00C);
        repeat (3) @(negedge clk);
        chk("R8 hold", {8'h0, bank_q}, 12'h00C);
        apply("R8 hold addr", 1'b1, 1'b0, 8'h07, 12'h000, 12'hC07);
        load_bank(4'hF);
        chk("R8 reload", {8'h0, bank_q}, 12'h00F);
    endtask

    initial begin
        rst_n = 1'b0; bank_load = 1'b0; bank_lit = 4'h0; fld = 8'h0;
        bank_sel = 1'b0; ext_en = 1'b0; stk_ptr = 12'h0; abs_sel = 1'b0; abs_addr = 12'h0;
        repeat (2) @(negedge clk);
        t_reset_r1();
        t_low_r2();
        t_high_r3();
        t_bank_r4();
        t_stack_r5();
        t_wrap_r6();
        t_abs_r7();
        t_load_r8();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #100000;
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule